// File: doc/BRIEF.md
# Four-Channel DAC Serial Command Front End

This block is the digital control side of a four-channel digital-to-analog converter. A host writes 32-bit frames over a three-wire serial link: a serial clock, a data line and an active-low frame strobe. Each frame carries a 4-bit command, a 4-bit channel address and a data code. Every channel holds three registers. The input register is staged, the DAC register drives the converter, and the clear-code register supplies the value that a clear loads.

A load-strobe input moves staged codes into the DAC registers. It works in two modes. Held low, it copies every pending channel as soon as new data is staged. Pulsed low, it copies on its falling edge. A clear input loads every channel from its clear code on a falling edge. For a fixed number of system clocks after reset, the load-strobe and clear inputs are ignored. In daisy-chain mode the previously received frame is shifted out on a serial output.

All serial and control pins are brought into the system clock domain through two-flop synchronisers. Serial clock falling edges are detected in that domain.

A receive state machine frames the bits. It has three states:
- `RX_IDLE`: waits with the strobe high. It moves to `RX_SHIFT` when the strobe goes low.
- `RX_SHIFT`: takes one bit on each serial clock falling edge. It returns to `RX_IDLE` if the strobe rises early, which discards the frame. It moves to `RX_HOLD` on the 32nd edge, which executes the frame.
- `RX_HOLD`: ignores further edges. It returns to `RX_IDLE` when the strobe rises.

Top module: `qdac_serial_if`

## Requirements
- R1: While `sync_n` is low, `din` is shifted in on each falling edge of `sclk`, most significant bit first. The frame layout is: command in bits 31:28, address in bits 27:24, code in bits 23:8, bits 7:0 ignored. Address 0 to 3 selects channel A to D, and address 15 selects all four channels.
- R2: A frame executes on the 32nd falling `sclk` edge. Further edges before `sync_n` rises have no effect.
- R3: If `sync_n` rises before the 32nd falling edge, the frame is discarded and no register changes.
- R4: Command 0 writes the code into the input registers of the addressed channels and marks them pending. The DAC registers keep their value while `ldac_n` stays high.
- R5: While `daisy_en` is off, `ldac_n` low copies every pending, unmasked input register into its DAC register. A pulse and a held-low level both do this. Command 6 loads the mask from the low four code bits, where bit n set blocks channel n.
- R6: The update commands work as follows:
  - Command 1 copies the input register to the DAC register for the addressed channels.
  - Command 3 writes the code into both the input and DAC registers of the addressed channels.
  - Command 2 writes the addressed input register, then copies all four input registers to their DAC registers.
- R7: Command 5 stores the code as the clear code of the addressed channels. A falling edge on `clr_n` loads every input register and DAC register with its channel's clear code.
- R8: After reset, every input and DAC register holds 0x8000 if `mid_strap` is 1, or 0x0000 if it is 0. Clear codes, mask, power-down modes and daisy mode are all zero. Command 7 returns the block to this state.
- R9: For `POR_CYCLES` system clocks after reset release, falling edges on `clr_n` and a low `ldac_n` change nothing.
- R10: Command 4 sets the power-down mode of the addressed channels from the two lowest code bits: 0 normal, 1 1 kΩ to ground, 2 100 kΩ to ground, 3 high impedance. Channel n uses `pd_mode` bits 2n+1:2n. Writes still change the registers of a powered-down channel.
- R11: Command 8 sets daisy mode from code bit 0. In daisy mode, `sdo` presents the previously received frame, most significant bit first, advancing one bit per falling `sclk` edge. With daisy mode off, `sdo` is 0.
- R12: In daisy mode, only a falling edge of `ldac_n` copies pending channels. Holding it low does not copy data staged afterwards.
- R13: Commands 9 to 15 are ignored. A frame whose address is 4 to 14 is ignored whatever its command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mid_strap | input | 1 | Reset level select: 1 midscale, 0 zero scale |
| sclk | input | 1 | Serial clock, idle high |
| sync_n | input | 1 | Active-low frame strobe |
| din | input | 1 | Serial data in |
| ldac_n | input | 1 | Active-low load strobe |
| clr_n | input | 1 | Clear, falling-edge active |
| sdo | output | 1 | Serial data out in daisy mode |
| dac_code | output | 64 | DAC registers, channel n in bits 16n+15:16n |
| pd_mode | output | 8 | Power-down mode, 2 bits per channel |

## Verification
Frames are sent with distinct codes per channel. A write that only stages data can therefore be told apart from one that reaches the DAC register, and a single-channel write from a broadcast. The load strobe is driven in three ways: as a short pulse, held low, and held low in daisy mode. This separates level-triggered copying from edge-triggered copying, and it exposes mask handling through a channel left at its old value. Truncated and overlong frames show whether execution is tied to exactly the 32nd edge. A clear during the lockout window and a clear after it separate the lockout from the clear path. The bits captured on `sdo` during the next frame are compared with the frame sent before it.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int FRAME_W = 32;
    localparam int CMD_W   = 4;
    localparam int ADDR_W  = 4;
    localparam logic [ADDR_W-1:0] ADDR_ALL = 4'hF;

    typedef enum logic [CMD_W-1:0] {
        CMD_WR_IN      = 4'd0,
        CMD_UPD        = 4'd1,
        CMD_WR_UPD_ALL = 4'd2,
        CMD_WR_UPD     = 4'd3,
        CMD_PWR        = 4'd4,
        CMD_CLRCODE    = 4'd5,
        CMD_MASK       = 4'd6,
        CMD_RESET      = 4'd7,
        CMD_DAISY      = 4'd8
    } cmd_e;

    typedef enum logic [1:0] {
        PD_ON   = 2'd0,
        PD_1K   = 2'd1,
        PD_100K = 2'd2,
        PD_HIZ  = 2'd3
    } pd_e;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_HOLD  = 2'd2
    } rx_state_e;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx
    import qdac_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               sync_n_s,
    input  logic               din_s,
    output logic               frame_exec,
    output logic [FRAME_W-1:0] frame_word,
    output logic               sr_msb
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    rx_state_e          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] sr_q;
    logic               sclk_d;
    logic               exec_q;
    logic               sclk_fall;

    assign sclk_fall = sclk_d && !sclk_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (!sync_n_s) state_d = RX_SHIFT;
            RX_SHIFT: begin
                if (sync_n_s)                         state_d = RX_IDLE;
                else if (sclk_fall && cnt_q == LAST)  state_d = RX_HOLD;
            end
            RX_HOLD:  if (sync_n_s) state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sr_q   <= '0;
            sclk_d <= 1'b1;
            exec_q <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            exec_q <= 1'b0;
            if (state_q == RX_IDLE) cnt_q <= '0;
            if (state_q == RX_SHIFT && !sync_n_s && sclk_fall) begin
                sr_q  <= {sr_q[FRAME_W-2:0], din_s};
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST) exec_q <= 1'b1;
            end
        end
    end

    assign frame_exec = exec_q;
    assign frame_word = sr_q;
    assign sr_msb     = sr_q[FRAME_W-1];

    p_cnt_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(FRAME_W));
    p_exec_in_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exec_q |-> (state_q == RX_HOLD));
    p_abort_no_exec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_SHIFT && sync_n_s) |=> !exec_q);
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
    import qdac_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int CODE_W     = 16,
    parameter int POR_CYCLES = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mid_strap,
    input  logic                  ldac_n_s,
    input  logic                  clr_n_s,
    input  logic                  frame_exec,
    input  logic [FRAME_W-1:0]    frame_word,
    output logic [NCH*CODE_W-1:0] dac_flat,
    output logic [2*NCH-1:0]      pd_flat,
    output logic                  daisy_en
);
    localparam int PW       = $clog2(POR_CYCLES + 1);
    localparam int CODE_TOP = FRAME_W - CMD_W - ADDR_W - 1;
    localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

    logic [CODE_W-1:0] inreg_q  [NCH];
    logic [CODE_W-1:0] dacreg_q [NCH];
    logic [CODE_W-1:0] clrcode_q[NCH];
    pd_e               pd_q     [NCH];
    logic [NCH-1:0]    pending_q;
    logic [NCH-1:0]    mask_q;
    logic              daisy_q;
    logic              ldac_d, clr_d;
    logic [PW-1:0]     por_cnt_q;

    logic              lockout;
    logic              ldac_fire, clr_fire;
    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] code;
    logic [NCH-1:0]    sel;
    logic [CODE_W-1:0] rst_code;

    assign cmd      = frame_word[FRAME_W-1 -: CMD_W];
    assign addr     = frame_word[FRAME_W-CMD_W-1 -: ADDR_W];
    assign code     = frame_word[CODE_TOP -: CODE_W];
    assign rst_code = mid_strap ? MID : '0;
    assign lockout  = (por_cnt_q != PW'(POR_CYCLES));
    assign ldac_fire = !lockout && (daisy_q ? (ldac_d && !ldac_n_s) : !ldac_n_s);
    assign clr_fire  = !lockout && clr_d && !clr_n_s;

    always_comb begin
        for (int ch = 0; ch < NCH; ch++)
            sel[ch] = (addr == ADDR_W'(ch)) || (addr == ADDR_ALL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int ch = 0; ch < NCH; ch++) begin
                inreg_q[ch]   <= rst_code;
                dacreg_q[ch]  <= rst_code;
                clrcode_q[ch] <= '0;
                pd_q[ch]      <= PD_ON;
            end
            pending_q <= '0;
            mask_q    <= '0;
            daisy_q   <= 1'b0;
            ldac_d    <= 1'b1;
            clr_d     <= 1'b1;
            por_cnt_q <= '0;
        end else begin
            ldac_d <= ldac_n_s;
            clr_d  <= clr_n_s;
            if (lockout) por_cnt_q <= por_cnt_q + 1'b1;

            if (ldac_fire) begin
                for (int ch = 0; ch < NCH; ch++) begin
                    if (pending_q[ch] && !mask_q[ch]) begin
                        dacreg_q[ch]  <= inreg_q[ch];
                        pending_q[ch] <= 1'b0;
                    end
                end
            end

            if (frame_exec && |sel) begin
                case (cmd)
                    CMD_WR_IN: begin
                        for (int ch = 0; ch < NCH; ch++) begin
                            if (sel[ch]) begin
                                inreg_q[ch]   <= code;
                                pending_q[ch] <= 1'b1;
                            end
                        end
                    end
                    CMD_UPD: begin
                        for (int ch = 0; ch < NCH; ch++) begin
                            if (sel[ch]) begin
                                dacreg_q[ch]  <= inreg_q[ch];
                                pending_q[ch] <= 1'b0;
                            end
                        end
                    end
                    CMD_WR_UPD_ALL: begin
                        for (int ch = 0; ch < NCH; ch++) begin
                            if (sel[ch]) begin
                                inreg_q[ch]  <= code;
                                dacreg_q[ch] <= code;
                            end else begin
                                dacreg_q[ch] <= inreg_q[ch];
                            end
                        end
                        pending_q <= '0;
                    end
                    CMD_WR_UPD: begin
                        for (int ch = 0; ch < NCH; ch++) begin
                            if (sel[ch]) begin
                                inreg_q[ch]   <= code;
                                dacreg_q[ch]  <= code;
                                pending_q[ch] <= 1'b0;
                            end
                        end
                    end
                    CMD_PWR: begin
                        for (int ch = 0; ch < NCH; ch++)
                            if (sel[ch]) pd_q[ch] <= pd_e'(code[1:0]);
                    end
                    CMD_CLRCODE: begin
                        for (int ch = 0; ch < NCH; ch++)
                            if (sel[ch]) clrcode_q[ch] <= code;
                    end
                    CMD_MASK:  mask_q  <= code[NCH-1:0];
                    CMD_DAISY: daisy_q <= code[0];
                    CMD_RESET: begin
                        for (int ch = 0; ch < NCH; ch++) begin
                            inreg_q[ch]   <= rst_code;
                            dacreg_q[ch]  <= rst_code;
                            clrcode_q[ch] <= '0;
                            pd_q[ch]      <= PD_ON;
                        end
                        pending_q <= '0;
                        mask_q    <= '0;
                        daisy_q   <= 1'b0;
                    end
                    default: ;
                endcase
            end

            if (clr_fire) begin
                for (int ch = 0; ch < NCH; ch++) begin
                    inreg_q[ch]  <= clrcode_q[ch];
                    dacreg_q[ch] <= clrcode_q[ch];
                end
                pending_q <= '0;
            end
        end
    end

    logic [NCH*CODE_W-1:0] clr_flat;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign dac_flat[g*CODE_W +: CODE_W] = dacreg_q[g];
        assign clr_flat[g*CODE_W +: CODE_W] = clrcode_q[g];
        assign pd_flat[2*g +: 2]            = pd_q[g];

        p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ldac_fire && mask_q[g] && !frame_exec && !clr_fire) |=> $stable(dacreg_q[g]));
    end

    assign daisy_en = daisy_q;

    p_lockout_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lockout && !frame_exec) |=> $stable(dac_flat));
    p_clr_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fire |=> (dac_flat == $past(clr_flat)));
endmodule

// File: rtl/qdac_serial_if.sv
module qdac_serial_if
    import qdac_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int CODE_W     = 16,
    parameter int POR_CYCLES = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mid_strap,
    input  logic                  sclk,
    input  logic                  sync_n,
    input  logic                  din,
    input  logic                  ldac_n,
    input  logic                  clr_n,
    output logic                  sdo,
    output logic [NCH*CODE_W-1:0] dac_code,
    output logic [2*NCH-1:0]      pd_mode
);
    localparam int NSYNC = 5;

    logic [NSYNC-1:0]   pins_s;
    logic               sclk_s, sync_n_s, din_s, ldac_n_s, clr_n_s;
    logic               frame_exec;
    logic [FRAME_W-1:0] frame_word;
    logic               sr_msb;
    logic               daisy_en;
    logic               sdo_q;

    qdac_sync #(.W(NSYNC), .RST_VAL({NSYNC{1'b1}})) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk, sync_n, din, ldac_n, clr_n}),
        .q     (pins_s)
    );
    assign {sclk_s, sync_n_s, din_s, ldac_n_s, clr_n_s} = pins_s;

    qdac_frame_rx i_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (sclk_s),
        .sync_n_s   (sync_n_s),
        .din_s      (din_s),
        .frame_exec (frame_exec),
        .frame_word (frame_word),
        .sr_msb     (sr_msb)
    );

    qdac_regs #(.NCH(NCH), .CODE_W(CODE_W), .POR_CYCLES(POR_CYCLES)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .mid_strap  (mid_strap),
        .ldac_n_s   (ldac_n_s),
        .clr_n_s    (clr_n_s),
        .frame_exec (frame_exec),
        .frame_word (frame_word),
        .dac_flat   (dac_code),
        .pd_flat    (pd_mode),
        .daisy_en   (daisy_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sdo_q <= 1'b0;
        else        sdo_q <= daisy_en && sr_msb;
    end
    assign sdo = sdo_q;

    p_sdo_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !daisy_en |=> !sdo);
endmodule

// File: tb/test_qdac_serial_if.sv
module test_qdac_serial_if;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mid_strap = 1'b1;
    logic sclk = 1'b1, sync_n = 1'b1, din = 1'b0, ldac_n = 1'b1, clr_n = 1'b1;
    logic sdo;
    logic [63:0] dac_code;
    logic [7:0]  pd_mode;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] exp_dac [4];
    logic [31:0] sdo_cap;

    always #4 clk = ~clk;

    qdac_serial_if i_qdac_serial_if (
        .clk(clk), .rst_n(rst_n), .mid_strap(mid_strap), .sclk(sclk),
        .sync_n(sync_n), .din(din), .ldac_n(ldac_n), .clr_n(clr_n),
        .sdo(sdo), .dac_code(dac_code), .pd_mode(pd_mode)
    );

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, expv);
        end
    endtask

    task automatic chk_dacs(input string tag);
        for (int c = 0; c < 4; c++)
            chk(tag, {16'h0, dac_code[16*c +: 16]}, {16'h0, exp_dac[c]});
    endtask

    task automatic send(input logic [31:0] w, input int nbits);
        sync_n = 1'b0;
        idle(6);
        for (int i = 0; i < nbits; i++) begin
            din = (i < 32) ? w[31-i] : 1'b0;
            if (i < 32) sdo_cap[31-i] = sdo;
            idle(3);
            sclk = 1'b0;
            idle(6);
            sclk = 1'b1;
            idle(3);
        end
        sync_n = 1'b1;
        idle(8);
    endtask

    task automatic pulse_ldac;
        ldac_n = 1'b0; idle(6); ldac_n = 1'b1; idle(6);
    endtask

    task automatic t_reset;
        for (int c = 0; c < 4; c++) exp_dac[c] = 16'h8000;
        chk_dacs("R8 reset midscale");
        chk("R10 reset pd", {24'h0, pd_mode}, 32'h0);
        chk("R11 reset sdo", {31'h0, sdo}, 32'h0);
    endtask

    task automatic t_lockout;
        clr_n = 1'b0; idle(4); clr_n = 1'b1; idle(4);
        chk_dacs("R9 clr in lockout ignored");
        idle(100);
    endtask

    task automatic t_write_input;
        send(32'h00123400, 32);
        chk_dacs("R4 staged only");
        pulse_ldac();
        exp_dac[0] = 16'h1234;
        chk_dacs("R5 ldac pulse");
    endtask

    task automatic t_update_cmds;
        send(32'h3F0F0F00, 32);
        for (int c = 0; c < 4; c++) exp_dac[c] = 16'h0F0F;
        chk_dacs("R6 R1 broadcast write-update");
        send(32'h01AAAA00, 32);
        chk_dacs("R4 ch1 staged");
        send(32'h11000000, 32);
        exp_dac[1] = 16'hAAAA;
        chk_dacs("R6 update cmd1");
        send(32'h02555500, 32);
        send(32'h23333300, 32);
        exp_dac[2] = 16'h5555; exp_dac[3] = 16'h3333;
        chk_dacs("R6 write-update-all cmd2");
    endtask

    task automatic t_framing;
        send(32'h30777700, 20);
        chk_dacs("R3 short frame discarded");
        send(32'h30444400, 34);
        exp_dac[0] = 16'h4444;
        chk_dacs("R2 overlong frame");
    endtask

    task automatic t_mask;
        send(32'h60000200, 32);
        send(32'h0F111100, 32);
        pulse_ldac();
        exp_dac[0] = 16'h1111; exp_dac[2] = 16'h1111; exp_dac[3] = 16'h1111;
        chk_dacs("R5 mask ch1");
        send(32'h60000000, 32);
    endtask

    task automatic t_clear;
        send(32'h520ABC00, 32);
        clr_n = 1'b0; idle(6); clr_n = 1'b1; idle(6);
        for (int c = 0; c < 4; c++) exp_dac[c] = 16'h0000;
        exp_dac[2] = 16'h0ABC;
        chk_dacs("R7 clear");
        send(32'h12000000, 32);
        chk_dacs("R7 input cleared too");
    endtask

    task automatic t_power;
        send(32'h41000200, 32);
        chk("R10 pd ch1", {24'h0, pd_mode}, 32'h08);
        send(32'h31222200, 32);
        exp_dac[1] = 16'h2222;
        chk_dacs("R10 write while down");
        chk("R10 pd kept", {24'h0, pd_mode}, 32'h08);
        send(32'h4F000300, 32);
        chk("R10 pd all hiz", {24'h0, pd_mode}, 32'hFF);
        send(32'h4F000000, 32);
        chk("R10 pd all on", {24'h0, pd_mode}, 32'h00);
    endtask

    task automatic t_ignore;
        send(32'h90999900, 32);
        chk_dacs("R13 unknown cmd");
        send(32'h355A5A00, 32);
        chk_dacs("R13 bad address");
    endtask

    task automatic t_level_ldac;
        ldac_n = 1'b0; idle(6);
        send(32'h00666600, 32);
        exp_dac[0] = 16'h6666;
        chk_dacs("R5 ldac held low");
        ldac_n = 1'b1; idle(6);
    endtask

    task automatic t_daisy;
        send(32'h80000100, 32);
        ldac_n = 1'b0; idle(6);
        send(32'h00135700, 32);
        chk("R11 sdo previous frame", sdo_cap, 32'h80000100);
        chk_dacs("R12 held low no copy");
        ldac_n = 1'b1; idle(6);
        ldac_n = 1'b0; idle(6);
        ldac_n = 1'b1; idle(6);
        exp_dac[0] = 16'h1357;
        chk_dacs("R12 edge copy");
        mid_strap = 1'b0;
        send(32'h70000000, 32);
        for (int c = 0; c < 4; c++) exp_dac[c] = 16'h0000;
        chk_dacs("R8 reset cmd zero strap");
        chk("R11 sdo off after reset", {31'h0, sdo}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_lockout();
        t_write_input();
        t_update_cmds();
        t_framing();
        t_mask();
        t_clear();
        t_power();
        t_ignore();
        t_level_ldac();
        t_daisy();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule